// File: doc/BRIEF.md
# Serial Clock Synthesizer Programmer

This block writes a divider configuration into an external programmable frequency generator over three bit-banged wires: a select strobe, a serial data line and a serial clock. A configuration is made of five fields (n, m, v, x, r). The block packs them with a constant trailer into a 24-bit word and shifts the word out. Each clock phase lasts a programmable number of system clocks. When the word has been sent, the block pulses done and stops driving all three wires.

Each pin comes out as a value and an output enable, so the pad ring can build a tri-state buffer. The block holds a built-in default configuration for a 1.5 MHz output. It sends this default automatically after reset, and again whenever load_default_i is pulsed. A user request carries a target-frequency word with the fields. A request whose frequency word is zero is treated as empty and dropped.

Top module: `synth_prog`

## Requirements
- R1: After reset is released, the block sends the default configuration n=120, m=100, v=1, x=1, r=2 without any request. While reset is held, busy_o is 0 and all three output enables are 0.
- R2: The 24-bit word on the wire is ordered as follows. n takes bits 0-6 and m takes bits 7-13. v is bit 14, x takes bits 15-16 and r takes bits 17-18. The trailer 0x17 takes bits 19-23, giving the sequence 1,1,1,0,1. Every field is sent least significant bit first.
- R3: Each bit has three phases of HALF_CYC system clocks each. First the clock is low with the data value set, then the clock is high, then the clock is low again. Data does not change while the clock is high.
- R4: When a transfer is accepted, all three lines become driven with select high and data and clock low, for HALF_CYC clocks. Select then goes low and stays low for the rest of the transfer. This gives 2*HALF_CYC clocks of low select before the first rising edge of the serial clock.
- R5: After the final low phase of the last trailer bit, all three output enables drop to 0 in the same cycle in which done_o pulses high for exactly one cycle. No line is driven while busy_o is 0.
- R6: A start_i pulse with freq_i equal to zero is ignored. busy_o stays 0 and no line is driven.
- R7: While busy_o is 1, start_i is ignored. The word in flight is not changed, and no second transfer follows.
- R8: load_default_i starts a transfer of the default configuration. If it arrives in the same cycle as start_i, load_default_i takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send the user configuration |
| load_default_i | input | 1 | Request to send the default configuration |
| freq_i | input | FREQ_W | Target frequency tag; zero cancels the request |
| n_i | input | 7 | Field n |
| m_i | input | 7 | Field m |
| v_i | input | 1 | Field v |
| x_i | input | 2 | Field x |
| r_i | input | 2 | Field r |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| sel_o | output | 1 | Select line value |
| sel_oe_o | output | 1 | Select line output enable |
| sdata_o | output | 1 | Serial data value |
| sdata_oe_o | output | 1 | Serial data output enable |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe_o | output | 1 | Serial clock output enable |

## Verification
The bench rebuilds each expected word one bit at a time from the field list. It captures data on every rising edge of the serial clock, so a design that swaps field order or sends a field MSB-first shows a wrong captured word. It measures the high time of the clock, the preamble with select high and the lead with select low, which exposes off-by-one phase counters and a missing select frame. It also checks that the enables are low at done, and it sends zero-frequency, busy-time and simultaneous requests. These catch a design that leaves the pins driven, starts a transfer on an empty request, restarts in the middle of a word, or lets the user request win over the default.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int N_W   = 7;
  localparam int M_W   = 7;
  localparam int V_W   = 1;
  localparam int X_W   = 2;
  localparam int R_W   = 2;
  localparam int TRL_W = 5;
  localparam int CFG_W  = N_W + M_W + V_W + X_W + R_W;
  localparam int WORD_W = CFG_W + TRL_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam logic [TRL_W-1:0] TRL_VAL = 5'h17;

  // packed: first member is MSB, so n lands in the low bits
  typedef struct packed {
    logic [R_W-1:0] r;
    logic [X_W-1:0] x;
    logic [V_W-1:0] v;
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } cfg_t;

  localparam cfg_t DEF_CFG = '{r: 2'd2, x: 2'd1, v: 1'b1, m: 7'd100, n: 7'd120};

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SELLO, ST_BSET, ST_BHI, ST_BLO, ST_FIN
  } st_e;
endpackage

// File: rtl/synth_phase_tmr.sv
module synth_phase_tmr #(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (HALF_CYC <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      localparam int CNT_W = $clog2(HALF_CYC);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);
      logic [CNT_W-1:0] cnt_q;
      assign tick_o = run_i && (cnt_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (!run_i)      cnt_q <= '0;
        else if (tick_o)      cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/synth_req_arb.sv
module synth_req_arb
  import synth_prog_pkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              idle_i,
  input  logic              init_i,
  input  logic              ld_def_i,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  cfg_t              usr_cfg_i,
  output logic              go_o,
  output logic [WORD_W-1:0] word_o
);
  logic use_def;
  cfg_t sel_cfg;

  assign use_def = init_i || ld_def_i;
  assign go_o    = idle_i && (use_def || (start_i && (|freq_i)));
  assign sel_cfg = use_def ? DEF_CFG : usr_cfg_i;
  assign word_o  = {TRL_VAL, sel_cfg};
endmodule

// File: rtl/synth_seq.sv
module synth_seq
  import synth_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tick_i,
  output logic              idle_o,
  output logic              run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sel_o,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              drive_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  st_e st_q, st_d;
  logic [WORD_W-1:0] word_q;
  logic [BIT_W-1:0]  idx_q;
  logic              in_bit;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (go_i)   st_d = ST_PRE;
      ST_PRE:   if (tick_i) st_d = ST_SELLO;
      ST_SELLO: if (tick_i) st_d = ST_BSET;
      ST_BSET:  if (tick_i) st_d = ST_BHI;
      ST_BHI:   if (tick_i) st_d = ST_BLO;
      ST_BLO:   if (tick_i) st_d = (idx_q == LAST_BIT) ? ST_FIN : ST_BSET;
      ST_FIN:               st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      word_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && go_i) begin
        word_q <= word_i;
        idx_q  <= '0;
      end else if (st_q == ST_BLO && tick_i && idx_q != LAST_BIT) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign in_bit  = (st_q == ST_BSET) || (st_q == ST_BHI) || (st_q == ST_BLO);
  assign idle_o  = (st_q == ST_IDLE);
  assign run_o   = !idle_o && (st_q != ST_FIN);
  assign busy_o  = !idle_o;
  assign done_o  = (st_q == ST_FIN);
  assign drive_o = run_o;
  assign sel_o   = (st_q == ST_PRE);
  assign sclk_o  = (st_q == ST_BHI);
  assign sdata_o = in_bit && word_q[idx_q];
endmodule

// File: rtl/synth_prog.sv
module synth_prog
  import synth_prog_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int FREQ_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_default_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [6:0]        n_i,
  input  logic [6:0]        m_i,
  input  logic              v_i,
  input  logic [1:0]        x_i,
  input  logic [1:0]        r_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sel_o,
  output logic              sel_oe_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              sclk_o,
  output logic              sclk_oe_o
);
  cfg_t              usr_cfg;
  logic              init_q;
  logic              go, idle, run, tick, drive;
  logic [WORD_W-1:0] word;

  assign usr_cfg = '{r: r_i, x: x_i, v: v_i, m: m_i, n: n_i};

  // default load pending from reset until first accepted transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  init_q <= 1'b1;
    else if (go)  init_q <= 1'b0;
  end

  synth_req_arb #(.FREQ_W(FREQ_W)) u_arb (
    .idle_i    (idle),
    .init_i    (init_q),
    .ld_def_i  (load_default_i),
    .start_i   (start_i),
    .freq_i    (freq_i),
    .usr_cfg_i (usr_cfg),
    .go_o      (go),
    .word_o    (word)
  );

  synth_phase_tmr #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  synth_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .word_i  (word),
    .tick_i  (tick),
    .idle_o  (idle),
    .run_o   (run),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sel_o   (sel_o),
    .sdata_o (sdata_o),
    .sclk_o  (sclk_o),
    .drive_o (drive)
  );

  assign sel_oe_o   = drive;
  assign sdata_oe_o = drive;
  assign sclk_oe_o  = drive;
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic sel_o,
  input logic sel_oe_o,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic sclk_o,
  input logic sclk_oe_o
);
  p_idle_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(sel_oe_o || sdata_oe_o || sclk_oe_o));

  p_done_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(sel_oe_o || sdata_oe_o || sclk_oe_o));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_rise_sel_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (sel_oe_o && !sel_o));

  p_frame_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_oe_o) |-> (sel_o && !sclk_o && !sdata_o));

  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
endmodule

bind synth_prog synth_prog_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .sel_o      (sel_o),
  .sel_oe_o   (sel_oe_o),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o),
  .sclk_o     (sclk_o),
  .sclk_oe_o  (sclk_oe_o)
);

// File: tb/synth_prog_bench.sv
`timescale 1ns/1ps
module synth_prog_bench;
  localparam int HALF = 4;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, load_default_i = 0;
  logic [31:0] freq_i = 0;
  logic [6:0] n_i = 0, m_i = 0;
  logic v_i = 0;
  logic [1:0] x_i = 0, r_i = 0;
  logic busy_o, done_o, sel_o, sel_oe_o, sdata_o, sdata_oe_o, sclk_o, sclk_oe_o;

  always #2 clk = ~clk;

  synth_prog #(.HALF_CYC(HALF), .FREQ_W(32)) u_synth_prog (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .load_default_i(load_default_i),
    .freq_i(freq_i), .n_i(n_i), .m_i(m_i), .v_i(v_i), .x_i(x_i), .r_i(r_i),
    .busy_o(busy_o), .done_o(done_o), .sel_o(sel_o), .sel_oe_o(sel_oe_o),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor, sampled on the falling edge
  logic [23:0] cap_w;
  int cap_n, hi_run, hi_min, hi_max, pre_n, lead_n, done_n, busy_seen;
  bit prev_sclk, hold_bad, rel_bad;
  logic prev_dat;

  task automatic clr();
    @(posedge clk); #1;
    cap_w = 0; cap_n = 0; hi_run = 0; hi_min = 999; hi_max = 0;
    pre_n = 0; lead_n = 0; busy_seen = 0; hold_bad = 0; rel_bad = 0;
  endtask

  initial begin
    cap_w = 0; cap_n = 0; hi_run = 0; hi_min = 999; hi_max = 0; pre_n = 0;
    lead_n = 0; done_n = 0; busy_seen = 0; prev_sclk = 0; prev_dat = 0;
    hold_bad = 0; rel_bad = 0;
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (busy_o) busy_seen++;
      if (sel_oe_o && sel_o) pre_n++;
      if (sel_oe_o && !sel_o && !sclk_o && cap_n == 0) lead_n++;
      if (sclk_o && !prev_sclk && sclk_oe_o && cap_n < 24) begin
        cap_w[cap_n] = sdata_o;
        cap_n++;
      end
      if (sclk_o && prev_sclk && sdata_o != prev_dat) hold_bad = 1;
      if (sclk_o) hi_run++;
      else if (prev_sclk) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0;
      end
      if (done_o) begin
        done_n++;
        if (sel_oe_o || sdata_oe_o || sclk_oe_o) rel_bad = 1;
      end
      prev_sclk = sclk_o;
      prev_dat  = sdata_o;
    end
  end

  function automatic logic [23:0] exp_word(input logic [6:0] n, input logic [6:0] m,
                                           input logic v, input logic [1:0] x, input logic [1:0] r);
    logic [23:0] w = 0;
    int p = 0;
    for (int i = 0; i < 7; i++) begin w[p] = n[i]; p++; end
    for (int i = 0; i < 7; i++) begin w[p] = m[i]; p++; end
    w[p] = v; p++;
    for (int i = 0; i < 2; i++) begin w[p] = x[i]; p++; end
    for (int i = 0; i < 2; i++) begin w[p] = r[i]; p++; end
    for (int i = 0; i < 5; i++) begin w[p] = (5'h17 >> i) & 1'b1; p++; end
    return w;
  endfunction

  task automatic wait_done(input int base);
    for (int i = 0; i < 600 && done_n == base; i++) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic check_frame(input string tag, input logic [23:0] expw);
    chk(cap_w == expw && cap_n == 24, {tag, " R2 word"}, cap_w, expw);
    chk(hi_min == HALF && hi_max == HALF, {tag, " R3 clock high time"}, hi_max, HALF);
    chk(!hold_bad, {tag, " R3 data hold"}, hold_bad, 0);
    chk(pre_n == HALF, {tag, " R4 preamble"}, pre_n, HALF);
    chk(lead_n == 2*HALF, {tag, " R4 select lead"}, lead_n, 2*HALF);
    chk(!rel_bad && !sel_oe_o && !sdata_oe_o && !sclk_oe_o, {tag, " R5 release"}, rel_bad, 0);
  endtask

  task automatic pulse(input logic st, input logic ld);
    @(posedge clk); #1;
    start_i = st; load_default_i = ld;
    @(posedge clk); #1;
    start_i = 0; load_default_i = 0;
  endtask

  // {n, m, v, x, r, zero_freq}
  localparam logic [19:0] VEC [6] = '{
    {7'h7F, 7'h00, 1'b0, 2'b11, 2'b00, 1'b0},
    {7'h01, 7'h40, 1'b1, 2'b01, 2'b10, 1'b0},
    {7'h55, 7'h2A, 1'b0, 2'b10, 2'b01, 1'b0},
    {7'h12, 7'h34, 1'b1, 2'b00, 2'b11, 1'b1},
    {7'h00, 7'h7F, 1'b1, 2'b00, 2'b11, 1'b0},
    {7'h3C, 7'h61, 1'b0, 2'b01, 2'b00, 1'b0}
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      finish_run();
    end
  end

  initial begin
    int d0;
    logic [23:0] defw;
    defw = exp_word(7'd120, 7'd100, 1'b1, 2'd1, 2'd2);

    repeat (3) @(negedge clk);
    chk(!busy_o && !sel_oe_o && !sdata_oe_o && !sclk_oe_o, "R1 reset state",
        {busy_o, sel_oe_o, sdata_oe_o, sclk_oe_o}, 0);
    @(posedge clk); #1 rst_ni = 1;
    wait_done(0);
    chk(done_n == 1, "R1 default after reset", done_n, 1);
    check_frame("R1", defw);

    foreach (VEC[k]) begin
      logic [19:0] e;
      e = VEC[k];
      clr();
      d0 = done_n;
      n_i = e[19:13]; m_i = e[12:6]; v_i = e[5]; x_i = e[4:3]; r_i = e[2:1];
      freq_i = e[0] ? 32'd0 : 32'd1000 + k;
      pulse(1, 0);
      if (e[0]) begin
        repeat (60) @(posedge clk);
        chk(busy_seen == 0 && done_n == d0 && !sel_oe_o, "R6 zero freq ignored", busy_seen, 0);
      end else begin
        wait_done(d0);
        chk(done_n == d0 + 1, "R2 vector done", done_n, d0 + 1);
        check_frame("R2 vec", exp_word(e[19:13], e[12:6], e[5], e[4:3], e[2:1]));
      end
    end

    // R7: start during busy is dropped
    clr();
    d0 = done_n;
    n_i = 7'h0F; m_i = 7'h70; v_i = 0; x_i = 2'b10; r_i = 2'b01; freq_i = 32'd5;
    pulse(1, 0);
    repeat (20) @(posedge clk);
    #1 n_i = 7'h33; m_i = 7'h11;
    pulse(1, 0);
    wait_done(d0);
    chk(cap_w == exp_word(7'h0F, 7'h70, 1'b0, 2'b10, 2'b01), "R7 word kept", cap_w,
        exp_word(7'h0F, 7'h70, 1'b0, 2'b10, 2'b01));
    repeat (50) @(posedge clk);
    chk(done_n == d0 + 1 && !busy_o, "R7 no second transfer", done_n, d0 + 1);

    // R8: default on request, wins over start
    clr();
    d0 = done_n;
    n_i = 7'h05; m_i = 7'h06; v_i = 0; x_i = 0; r_i = 0; freq_i = 32'd9;
    pulse(1, 1);
    wait_done(d0);
    chk(cap_w == defw, "R8 default wins", cap_w, defw);
    clr();
    d0 = done_n;
    pulse(0, 1);
    wait_done(d0);
    chk(cap_w == defw && done_n == d0 + 1, "R8 default on request", cap_w, defw);

    finish_run();
  end
endmodule